// File: doc/BRIEF.md
# Always-On Seconds Counter with One-Shot Alarm

This block keeps time in an always-on domain. A 47-bit counter advances once per period of a slow 32.768 kHz clock. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of a second. The slow clock reaches the block as a single-cycle enable pulse, `slow_tick`, on the bus clock. A plain 32-bit register bus exposes the following:

- a control word;
- a sticky status word;
- the counter, split into an upper and a lower word;
- a seconds alarm;
- a spare 32-bit scratch word.

The run request is written on the bus but only reaches the slow domain after a fixed number of slow ticks. Software polls the control word until the run bit reads back the value it asked for. The counter can be loaded only while it is really stopped. When the alarm is armed and the seconds field equals the alarm value, a status flag is set. An interrupt/wake output follows that flag, gated by both the alarm-arm bit and the wake-enable bit. Software reads the two counter words separately and repeats the pair of reads until two passes agree.

Top module: `lprtc_top`

## Requirements
- R1: After reset, every register reads zero (control, status, counter upper and lower words, alarm, scratch) and `irq` is low.
- R2: The counter adds one on each `slow_tick` while the effective run bit is set, and holds its value otherwise. The seconds value is counter bits 46..15.
- R3: A write to control bit 0 (run request) takes effect only on the third `slow_tick` after it. No count happens on that tick. Control bit 0 reads back the effective run state, not the request.
- R4: A write to offset 0x20 loads counter bits 31..0. A write to offset 0x1C loads counter bits 46..32 from write-data bits 14..0, and the upper word reads with bits 31..15 zero. Both writes are ignored while the effective run bit is set.
- R5: A carry out of counter bit 31 propagates into the upper word.
- R6: The alarm register at offset 0x24 takes a write only while control bit 1 (alarm arm) is clear. Otherwise the write is ignored.
- R7: Status bit 0 at offset 0x18 sets on the bus clock after control bit 1 is set and the seconds value equals the alarm register. It stays set after the arm bit is cleared.
- R8: Writing status with bit 0 set clears the flag, and 0xFFFFFFFF clears it as well. Writing 0 leaves it unchanged. A match in the same cycle wins over a clear.
- R9: `irq` equals status bit 0 AND control bit 1 AND control bit 3 (wake enable), registered one bus clock later.
- R10: Offset 0x30 is a plain read/write 32-bit scratch word. Reads of unmapped offsets return zero.
- R11: Read data appears on `rdata` one bus clock after `rd_en`. Control reads back with bit 0 = effective run, bit 1 = alarm arm, bit 3 = wake enable, and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt / wake request |

## Verification
A read strobed at one bus edge is due on `rdata` at the next edge. A scoreboard pushes the expected word when the strobe is driven, and the monitor compares it half a cycle after that edge. The bench supplies every slow tick itself and spaces each one by several bus clocks. This makes every count, the three-tick run handshake and the alarm match exact at the following read. Status sets one bus clock after the match and `irq` one clock after status, so both are sampled at least two clocks after the stimulus that causes them.

// File: rtl/lprtc_pkg.sv
package lprtc_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 47;
  localparam int FRAC_W   = 15;
  localparam int ADDR_W   = 8;
  localparam int SYNC_TK  = 3;

  // register offsets
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_CNTHI = 8'h1C;
  localparam logic [7:0] OFS_CNTLO = 8'h20;
  localparam logic [7:0] OFS_ALARM = 8'h24;
  localparam logic [7:0] OFS_SCRAT = 8'h30;

  // control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_ARM  = 1;
  localparam int CB_WAKE = 3;
  localparam int SB_HIT  = 0;

  typedef struct packed {
    logic wake;
    logic arm;
    logic run_req;
  } ctrl_t;
endpackage

// File: rtl/lprtc_en_sync.sv
module lprtc_en_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req,
  output logic act
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst)       pipe <= '0;
    else if (tick) pipe <= {pipe[STAGES-2:0], req};
  end

  assign act = pipe[STAGES-1];

  // R3
  act_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act));
endmodule

// File: rtl/lprtc_counter.sv
module lprtc_counter #(
  parameter int CNT_W  = 47,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  localparam int HI_W = CNT_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      if (tick) cnt <= cnt + 1'b1;
    end else begin
      if (ld_lo) cnt[DATA_W-1:0]     <= wdata;
      if (ld_hi) cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> (cnt == $past(cnt) + 1'b1));
  // R4
  no_load_running_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));
  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
endmodule

// File: rtl/lprtc_alarm.sv
module lprtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] seconds,
  input  logic             wr_alarm,
  input  logic [SEC_W-1:0] wdata,
  input  logic             arm,
  input  logic             wake,
  input  logic             clr,
  output logic [SEC_W-1:0] alarm_val,
  output logic             hit,
  output logic             irq
);
  logic match;
  assign match = arm && (seconds == alarm_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_val <= '0;
      hit       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_alarm && !arm) alarm_val <= wdata;
      hit <= (hit && !clr) || match;
      irq <= hit && arm && wake;
    end
  end

  // R6
  alarm_locked_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> $stable(alarm_val));
  // R7
  hit_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(arm));
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hit));
endmodule

// File: rtl/lprtc_top.sv
module lprtc_top
  import lprtc_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int CW   = CNT_W,
  parameter int FW   = FRAC_W,
  parameter int SYNC = SYNC_TK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int HI_W = CW - DW;
  localparam int SEC_W = CW - FW;
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CNTHI = AW'(OFS_CNTHI);
  localparam logic [AW-1:0] A_CNTLO = AW'(OFS_CNTLO);
  localparam logic [AW-1:0] A_ALARM = AW'(OFS_ALARM);
  localparam logic [AW-1:0] A_SCRAT = AW'(OFS_SCRAT);

  ctrl_t              ctrl_q;
  logic               run_act;
  logic [CW-1:0]      cnt;
  logic [SEC_W-1:0]   alarm_val;
  logic               hit;
  logic [DW-1:0]      scratch;

  logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alm, wr_scr;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_hi   = wr_en && (addr == A_CNTHI);
  assign wr_lo   = wr_en && (addr == A_CNTLO);
  assign wr_alm  = wr_en && (addr == A_ALARM);
  assign wr_scr  = wr_en && (addr == A_SCRAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      scratch <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run_req <= wdata[CB_RUN];
        ctrl_q.arm     <= wdata[CB_ARM];
        ctrl_q.wake    <= wdata[CB_WAKE];
      end
      if (wr_scr) scratch <= wdata;
    end
  end

  lprtc_en_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .tick(slow_tick),
    .req(ctrl_q.run_req), .act(run_act)
  );

  lprtc_counter #(.CNT_W(CW), .DATA_W(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(slow_tick), .run(run_act),
    .ld_lo(wr_lo), .ld_hi(wr_hi), .wdata(wdata), .cnt(cnt)
  );

  lprtc_alarm #(.SEC_W(SEC_W)) u_alm (
    .clk(clk), .rst(rst), .seconds(cnt[CW-1:FW]),
    .wr_alarm(wr_alm), .wdata(wdata[SEC_W-1:0]),
    .arm(ctrl_q.arm), .wake(ctrl_q.wake),
    .clr(wr_stat && wdata[SB_HIT]),
    .alarm_val(alarm_val), .hit(hit), .irq(irq)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CTRL: begin
        rd_mux[CB_RUN]  = run_act;
        rd_mux[CB_ARM]  = ctrl_q.arm;
        rd_mux[CB_WAKE] = ctrl_q.wake;
      end
      A_STAT:  rd_mux[SB_HIT] = hit;
      A_CNTHI: rd_mux[HI_W-1:0] = cnt[CW-1:DW];
      A_CNTLO: rd_mux = cnt[DW-1:0];
      A_ALARM: rd_mux = DW'(alarm_val);
      A_SCRAT: rd_mux = scratch;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/lprtc_top_test.sv
module lprtc_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  lprtc_top uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = a; sb.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    repeat (2) @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h04, 32'h0, "R1 ctrl");
    rd(8'h18, 32'h0, "R1 status");
    rd(8'h1C, 32'h0, "R1 cnt hi");
    rd(8'h20, 32'h0, "R1 cnt lo");
    rd(8'h24, 32'h0, "R1 alarm");
    rd(8'h30, 32'h0, "R1 scratch");
    chk_irq(1'b0, "R1 irq");
    // R10 scratch and unmapped
    wr(8'h30, 32'hA5C3_0F1E);
    rd(8'h30, 32'hA5C3_0F1E, "R10 scratch");
    rd(8'h10, 32'h0, "R10 unmapped");
    // R4 load while stopped
    wr(8'h20, 32'h0002_8000);
    wr(8'h1C, 32'h0);
    rd(8'h20, 32'h0002_8000, "R4 load lo");
    // R3 run handshake
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R3 run not yet");
    tick(2);
    rd(8'h04, 32'h0, "R3 run after 2 ticks");
    tick(1);
    rd(8'h04, 32'h1, "R3 run after 3 ticks");
    rd(8'h20, 32'h0002_8000, "R3 no count on sync tick");
    tick(1);
    rd(8'h20, 32'h0002_8001, "R2 count step");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h0002_8001, "R4 load ignored while running");
    // R3 stop handshake
    wr(8'h04, 32'h0);
    tick(2);
    rd(8'h04, 32'h1, "R3 stop delayed");
    tick(1);
    rd(8'h04, 32'h0, "R3 stopped");
    rd(8'h20, 32'h0002_8004, "R2 counts during stop sync");
    // R4 upper word mask, R5 carry
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_8003);
    rd(8'h1C, 32'h0000_0003, "R4 hi masked");
    tick(1);
    rd(8'h20, 32'hFFFF_FFFF, "R2 hold while stopped");
    wr(8'h04, 32'h1);
    tick(4);
    rd(8'h20, 32'h0, "R5 lo wrapped");
    rd(8'h1C, 32'h4, "R5 carry into hi");
    // alarm
    wr(8'h04, 32'h0);
    tick(3);
    wr(8'h20, 32'h0005_7FFE);
    wr(8'h1C, 32'h0);
    wr(8'h24, 32'd11);
    rd(8'h24, 32'd11, "R6 alarm write while disarmed");
    wr(8'h04, 32'hB);
    wr(8'h24, 32'd99);
    rd(8'h24, 32'd11, "R6 alarm write ignored while armed");
    tick(3);
    rd(8'h04, 32'hB, "R11 ctrl layout");
    rd(8'h18, 32'h0, "R7 no match yet");
    tick(1);
    rd(8'h20, 32'h0005_7FFF, "R2 fraction step");
    rd(8'h18, 32'h0, "R7 still 10 s");
    chk_irq(1'b0, "R9 irq before match");
    tick(1);
    rd(8'h18, 32'h1, "R7 match sets status");
    chk_irq(1'b1, "R9 irq asserted");
    wr(8'h04, 32'h3);
    chk_irq(1'b0, "R9 irq gated by wake");
    rd(8'h18, 32'h1, "R7 status kept");
    wr(8'h04, 32'h1);
    rd(8'h18, 32'h1, "R7 sticky after disarm");
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h1, "R8 write 0 no effect");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R8 all-ones clear");
    wr(8'h04, 32'h3);
    repeat (2) @(negedge clk);
    wr(8'h04, 32'h1);
    rd(8'h18, 32'h1, "R7 rematch");
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h0, "R8 single-bit clear");
    wr(8'h24, 32'd20);
    rd(8'h24, 32'd20, "R6 alarm write after disarm");
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule